// File: doc/BRIEF.md
# Single-Register MDIO Management Master

This block drives the two-wire management interface of an Ethernet PHY, the MDC clock and the MDIO data line, from one 32-bit command/status word. Software writes a single word that packs an opcode, a PHY address, a register address and 16 bits of write data. For a read or a write opcode the block shifts out a complete clause-22 style frame and then sets a ready flag that software polls.

On a read, the block releases MDIO at the turnaround and samples the PHY's 16-bit answer on rising MDC edges. When ready returns, that answer sits in the low half of the same word. MDC is made from the system clock by a parameterised divider and runs only while a frame is in flight. A frame must finish well inside 64 microseconds, so software can treat a longer wait as a timeout.

The command port is a plain register write strobe. There is no back-pressure: the ready bit is the only flow control. A write that arrives while ready is low is dropped.

Top module: `mdio_ctl_master`

## Requirements
- R1: After reset the status word reads 0x1000_0000 (ready bit 28 set, every other bit zero), MDC is low and mdio_oe is low.
- R2: The status word holds data in bits 15:0, register address in bits 20:16, PHY address in bits 25:21, opcode in bits 27:26, ready in bit 28 and zeros in bits 31:29. An accepted write is visible there one cycle later.
- R3: An accepted command with opcode 01 (write) or 10 (read) clears bit 28 in the cycle after the write strobe and starts a frame.
- R4: Opcodes 00 and 11 are stored in the word but leave bit 28 set, and no frame runs (MDC stays low, mdio_oe stays low).
- R5: A write strobe while bit 28 is clear changes nothing in the status word and does not disturb the running frame.
- R6: While a frame runs, MDC has a period of 2*DIV_HALF system clocks. Each bit starts with MDC low for DIV_HALF clocks, followed by DIV_HALF clocks high. MDC is low whenever the block is idle.
- R7: The frame carries 32 ones, then 01, then the two opcode bits, then the 5-bit PHY address and the 5-bit register address (both MSB first), then two turnaround bits and 16 data bits MSB first. mdio_o changes only where MDC falls, or at frame start.
- R8: On a write the turnaround is driven as 1 then 0, and mdio_oe stays high for all 64 bits. On a read mdio_oe goes low from bit 46 (the first turnaround bit) to the end of the frame.
- R9: On a read, mdio_i is sampled at each rising MDC edge of bits 48 to 63, MSB first. The 16-bit result appears in bits 15:0 in the same cycle that bit 28 sets.
- R10: Bit 28 sets again exactly 128*DIV_HALF system clocks after the accepting clock edge. MDC and mdio_oe are low from then on.
- R11: After a write frame completes, bits 15:0 still hold the data that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word |
| csr_rdata | output | 32 | Command/status word readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data received from the PHY |

## Verification
A wrong bit counter or divider phase shows up on MDC or mdio_o within one MDC period, and the ready flag then rises in the wrong cycle. A broken turnaround release appears on mdio_oe at bit 46. A wrong sampling edge or shift direction stays hidden until the end of the read frame, when bits 15:0 of the word differ from the value the PHY model sent. Every pin and the whole word are compared every clock against a behavioural timeline, so any of these faults is caught in the first cycle it reaches the ports.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    OP_NONE_LO = 2'b00,
    OP_WR      = 2'b01,
    OP_RD      = 2'b10,
    OP_NONE_HI = 2'b11
  } mdio_op_e;

  typedef struct packed {
    logic [2:0]        rsvd;
    logic              ready;
    mdio_op_e          op;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } csr_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign rise_evt = run && (cnt_q == LAST) && !mdc_q;
  assign fall_evt = run && (cnt_q == LAST) && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R6
  mdc_rise_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_ctl_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_op_e          op,
  input  logic [ADDR_W-1:0] phy,
  input  logic [ADDR_W-1:0] regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              fin,
  output logic [DATA_W-1:0] rd_result,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_BITS = PRE_BITS + 4 + 2*ADDR_W + 2 + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = PRE_BITS + 4 + 2*ADDR_W;
  localparam int DATA_POS   = TA_POS + 2;

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  busy_q;
  logic                  is_rd_q;
  logic [DATA_W-1:0]     rd_q;

  assign busy      = busy_q;
  assign fin       = busy_q && fall_evt && (idx_q == IDX_W'(FRAME_BITS - 1));
  assign rd_result = rd_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe   = busy_q && (!is_rd_q || (idx_q < IDX_W'(TA_POS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      is_rd_q <= 1'b0;
      rd_q    <= '0;
    end else if (start && !busy_q) begin
      sh_q    <= {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, 2'b10, wdata};
      idx_q   <= '0;
      busy_q  <= 1'b1;
      is_rd_q <= (op == OP_RD);
      rd_q    <= '0;
    end else if (busy_q) begin
      if (rise_evt && is_rd_q && (idx_q >= IDX_W'(DATA_POS)))
        rd_q <= {rd_q[DATA_W-2:0], mdio_i};
      if (fin) begin
        busy_q <= 1'b0;
      end else if (fall_evt) begin
        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R7
  launch_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_evt) |=> $stable(mdio_o));
  // R7
  preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (busy && mdio_oe && mdio_o));
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              fin,
  input  logic [DATA_W-1:0] rd_result,
  output logic              start,
  output mdio_op_e          op,
  output logic [ADDR_W-1:0] phy,
  output logic [ADDR_W-1:0] regad,
  output logic [DATA_W-1:0] wdata,
  output logic [31:0]       csr_rdata
);
  csr_t cmd_q;
  csr_t cmd_in;
  logic accept;

  assign cmd_in    = csr_t'(wr_data);
  assign accept    = wr_en && cmd_q.ready;
  assign start     = accept && ((cmd_in.op == OP_WR) || (cmd_in.op == OP_RD));
  assign op        = cmd_in.op;
  assign phy       = cmd_in.phy;
  assign regad     = cmd_in.regad;
  assign wdata     = cmd_in.data;
  assign csr_rdata = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= '0;
      cmd_q.ready <= 1'b1;
    end else if (accept) begin
      cmd_q.op    <= cmd_in.op;
      cmd_q.phy   <= cmd_in.phy;
      cmd_q.regad <= cmd_in.regad;
      cmd_q.data  <= cmd_in.data;
      cmd_q.ready <= !start;
    end else if (fin) begin
      cmd_q.ready <= 1'b1;
      if (cmd_q.op == OP_RD) cmd_q.data <= rd_result;
    end
  end

  // R4
  idle_op_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !start) |=> csr_rdata[28]);
  // R5
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !csr_rdata[28] && !fin) |=> $stable(csr_rdata));
  // R10
  fin_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> csr_rdata[28]);
endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
  import mdio_ctl_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] csr_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic              start, busy, fin, rise_evt, fall_evt;
  mdio_op_e          op;
  logic [ADDR_W-1:0] phy, regad;
  logic [DATA_W-1:0] wdata, rd_result;

  mdio_csr csr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fin(fin), .rd_result(rd_result), .start(start), .op(op),
    .phy(phy), .regad(regad), .wdata(wdata), .csr_rdata(csr_rdata)
  );

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_shifter #(.PRE_BITS(PRE_BITS)) shf_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .phy(phy),
    .regad(regad), .wdata(wdata), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .mdio_i(mdio_i), .busy(busy), .fin(fin), .rd_result(rd_result),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R3
  ready_low_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !csr_rdata[28]);
  // R10
  idle_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[28] |-> (!mdc && !mdio_oe));
endmodule

// File: tb/mdio_ctl_master_tb.sv
module mdio_ctl_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DH         = 2;
  localparam int NBITS      = 64;
  localparam int FRAME      = NBITS * 2 * DH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  logic        m_busy = 1'b0;
  int          m_t = 0;
  logic [1:0]  m_op = '0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [15:0] m_data = '0, m_rd = '0;
  logic [15:0] reply = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_ctl_master #(.DIV_HALF(DH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .csr_rdata(csr_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic frame_bit(input int b);
    logic [63:0] v;
    v = {32'hFFFF_FFFF, 2'b01, m_op, m_phy, m_reg, 2'b10, m_data};
    return v[63-b];
  endfunction

  task automatic tick();
    int b;
    logic [31:0] exp_csr;
    logic exp_oe;
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_op = 0; m_phy = 0; m_reg = 0; m_data = 0; m_rd = 0;
    end else if (m_busy) begin
      if (m_op == 2'b10 && (m_t % (2*DH)) == DH-1 && m_t/(2*DH) >= 48)
        m_rd = {m_rd[14:0], mdio_i};
      if (m_t == FRAME-1) begin
        m_busy = 0;
        if (m_op == 2'b10) m_data = m_rd;
      end else m_t++;
    end else if (wr_en) begin
      m_op = wr_data[27:26]; m_phy = wr_data[25:21];
      m_reg = wr_data[20:16]; m_data = wr_data[15:0];
      if (m_op == 2'b01 || m_op == 2'b10) begin
        m_busy = 1; m_t = 0; m_rd = 0;
      end
    end
    @(negedge clk);
    if (rst_n) begin
      exp_csr = {3'b000, !m_busy, m_op, m_phy, m_reg, m_data};
      check(csr_rdata == exp_csr,
            m_busy ? "R3 R5 word during frame" : "R2 R4 R9 R10 R11 word when idle",
            csr_rdata, exp_csr);
      b = m_t / (2*DH);
      check(mdc == (m_busy && ((m_t / DH) % 2 == 1)), "R6 mdc",
            {31'd0, mdc}, {31'd0, m_busy && ((m_t / DH) % 2 == 1)});
      exp_oe = m_busy && (m_op == 2'b01 || b < 46);
      check(mdio_oe == exp_oe, "R8 mdio_oe", {31'd0, mdio_oe}, {31'd0, exp_oe});
      if (exp_oe)
        check(mdio_o == frame_bit(b), "R7 mdio_o", {31'd0, mdio_o}, {31'd0, frame_bit(b)});
      if (m_busy && m_op == 2'b10 && b >= 48) mdio_i = reply[63-b];
      else mdio_i = 1'b1;
    end
  endtask

  task automatic cmd(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] word(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
    return {4'b0000, op, phy, ra, d};
  endfunction

  task automatic wait_idle();
    while (m_busy) tick();
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(csr_rdata == 32'h1000_0000, "R1 reset word", csr_rdata, 32'h1000_0000);
    check(!mdc && !mdio_oe, "R1 reset pins", {30'd0, mdc, mdio_oe}, 32'd0);

    // R4 opcodes 00 and 11: stored, ready stays set, no frame
    cmd(word(2'b00, 5'h03, 5'h0A, 16'h1234));
    repeat (6) tick();
    cmd(word(2'b11, 5'h1F, 5'h1F, 16'hFFFF));
    repeat (6) tick();

    // R3 R7 R8 R11 R6 R10 write frame, with R5 ignored write mid-frame
    cmd(word(2'b01, 5'h1B, 5'h17, 16'hA5C3));
    repeat (40) tick();
    cmd(word(2'b10, 5'h02, 5'h04, 16'h0F0F));
    wait_idle();

    // R9 read frame, PHY answers 0x3C96
    reply = 16'h3C96;
    cmd(word(2'b10, 5'h01, 5'h01, 16'h0000));
    wait_idle();

    // R9 back-to-back read with edge-pattern answer
    reply = 16'h8001;
    cmd(word(2'b10, 5'h15, 5'h0E, 16'hBEEF));
    wait_idle();

    // R5 write strobe landing on the completion edge is dropped
    reply = 16'h5AA5;
    cmd(word(2'b10, 5'h0C, 5'h03, 16'h0000));
    while (m_busy && m_t != FRAME-1) tick();
    cmd(word(2'b01, 5'h07, 5'h07, 16'h7777));
    repeat (8) tick();

    // R11 final write, data kept after completion
    cmd(word(2'b01, 5'h00, 5'h10, 16'h0001));
    wait_idle();
    repeat (4) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule